// File: doc/BRIEF.md
# Serial Codec Host Register Bank

This block is the host side of a full-duplex byte-serial codec. It holds two byte queues of 32 entries each: one for outgoing bytes on their way to the serial framer, one for incoming bytes from the deframer. Around the queues it keeps a set of registers on a simple address/data bus. These registers hold the path enables, the two fill thresholds, a live status word, an interrupt mask, and a sticky flag that records a change in symbol alignment.

Software writes outgoing bytes and reads incoming bytes through one data address. A write pushes to the outgoing queue and a read pops the incoming queue. The framer drains the outgoing queue through a show-ahead port with a take strobe. The deframer fills the incoming queue through a put strobe. One interrupt line is driven as the OR of every status bit whose mask bit is 1.

Top module: `codec_host_regs`

## Requirements
- R1: After reset the status word (0x0000) reads 0x011, the mask (0x0004) reads 0, both enable registers (0x0010, 0x0020) read 0, the outgoing threshold (0x0014) reads 8, the incoming threshold (0x0024) reads 16, and `irq_o` is 0.
- R2: A write to 0x0100 places `bus_wdata[7:0]` at the tail of the outgoing queue. The framer sees the bytes at `txq_byte` in write order while `txq_rdy` is 1. Each `txq_take` cycle removes the head. A write made while 32 bytes are held is dropped.
- R3: A read of 0x0100 returns the head of the incoming queue in `bus_rdata[7:0]` and removes it. If the queue is empty, the read returns 0 and changes nothing.
- R4: A `rxq_put` strobe appends `rxq_byte` to the incoming queue. A strobe that arrives while 32 bytes are held is dropped.
- R5: Status bit 0 is 1 exactly when the outgoing queue is empty, and bit 2 exactly when it holds 32 bytes. Bit 4 is 1 exactly when the incoming queue is empty, and bit 6 exactly when it holds 32 bytes.
- R6: Status bit 1 is 1 when the outgoing queue holds at least one byte and no more than the 5-bit threshold at 0x0014.
- R7: Status bit 5 is 1 when the incoming queue holds at least as many bytes as the 5-bit threshold at 0x0024.
- R8: Status bit 8 is set by an `align_chg_i` pulse. A status write with bit 8 at 1 clears it, and a write with bit 8 at 0 leaves it unchanged. A pulse in the same cycle as a clear wins.
- R9: Bit 0 of 0x0010 drives `tx_en_o`. Bit 0 of 0x0020 drives `rx_en_o`. Bit 1 of 0x0020 reads `align_i` and ignores writes.
- R10: `irq_o` is 1 exactly when some status bit and its mask bit (mask at 0x0004, bits 8:0) are both 1.
- R11: Bits outside each register's fields read 0 and ignore writes. Any address not listed reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| tx_en_o | output | 1 | Outgoing path enable |
| rx_en_o | output | 1 | Incoming path enable |
| txq_rdy | output | 1 | Outgoing queue holds a byte |
| txq_byte | output | 8 | Head of outgoing queue |
| txq_take | input | 1 | Framer removes the head |
| rxq_put | input | 1 | Deframer appends a byte |
| rxq_byte | input | 8 | Byte to append |
| align_i | input | 1 | Current alignment state |
| align_chg_i | input | 1 | One-cycle alignment change pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes, queue pushes and pops, and the sticky flag all update on the clock edge that samples the strobe. The status bits, `txq_byte` and `irq_o` follow combinationally from that state, so they are due just after that edge. Read data is captured on the edge that samples `bus_re` and is due in the following cycle. The bench drives strobes on falling edges. It samples `bus_rdata` on the falling edge after the capturing rising edge, and samples the queue and interrupt ports one falling edge after the update.

// File: rtl/codec_host_pkg.sv
package codec_host_pkg;
   // register byte addresses
   localparam int unsigned REG_STAT    = 32'h0000;
   localparam int unsigned REG_MASK    = 32'h0004;
   localparam int unsigned REG_TXCTL   = 32'h0010;
   localparam int unsigned REG_TXMARK  = 32'h0014;
   localparam int unsigned REG_RXCTL   = 32'h0020;
   localparam int unsigned REG_RXMARK  = 32'h0024;
   localparam int unsigned REG_DATA    = 32'h0100;

   // status word bit positions
   localparam int unsigned ST_TX_EMPTY = 0;
   localparam int unsigned ST_TX_LOW   = 1;
   localparam int unsigned ST_TX_FULL  = 2;
   localparam int unsigned ST_RX_EMPTY = 4;
   localparam int unsigned ST_RX_HIGH  = 5;
   localparam int unsigned ST_RX_FULL  = 6;
   localparam int unsigned ST_ALN_EVT  = 8;
   localparam int unsigned STAT_W      = 9;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_STAT, SEL_MASK, SEL_TXCTL,
      SEL_TXMARK, SEL_RXCTL, SEL_RXMARK, SEL_DATA
   } reg_sel_e;
endpackage

// File: rtl/codec_byte_fifo.sv
module codec_byte_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("codec_byte_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop  && (count != '0);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH) && push && !pop) |=> (count == CW'(DEPTH)));
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push) |=> (count == '0));
   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/codec_mark_cmp.sv
module codec_mark_cmp #(
   parameter int unsigned CW    = 6,
   parameter int unsigned MW    = 5,
   parameter bit          ABOVE = 1'b0
) (
   input  logic [CW-1:0] count,
   input  logic [MW-1:0] mark,
   output logic          hit
);
   if (MW > CW) begin : g_bad_width
      $error("codec_mark_cmp: mark wider than count");
   end

   logic [CW-1:0] mark_x;
   assign mark_x = CW'(mark);

   if (ABOVE) begin : g_at_or_above
      assign hit = (count >= mark_x);
   end else begin : g_at_or_below
      assign hit = (count != '0) && (count <= mark_x);
   end
endmodule

// File: rtl/codec_host_regs.sv
module codec_host_regs
   import codec_host_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned BUS_W      = 32,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned DEPTH      = 32,
   parameter int unsigned MARK_W     = 5,
   parameter int unsigned TX_MARK_RST = 8,
   parameter int unsigned RX_MARK_RST = 16,
   localparam int unsigned CW        = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              tx_en_o,
   output logic              rx_en_o,
   output logic              txq_rdy,
   output logic [BYTE_W-1:0] txq_byte,
   input  logic              txq_take,
   input  logic              rxq_put,
   input  logic [BYTE_W-1:0] rxq_byte,
   input  logic              align_i,
   input  logic              align_chg_i,
   output logic              irq_o
);
   if (BUS_W < STAT_W || BUS_W < BYTE_W || BUS_W < MARK_W) begin : g_bad_bus
      $error("codec_host_regs: BUS_W too narrow for register fields");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("codec_host_regs: ADDR_W too narrow for the map");
   end
   if (TX_MARK_RST >= (1 << MARK_W) || RX_MARK_RST >= (1 << MARK_W)) begin : g_bad_mark
      $error("codec_host_regs: threshold reset does not fit MARK_W");
   end

   reg_sel_e sel;
   always_comb begin
      unique case (bus_addr)
         ADDR_W'(REG_STAT):   sel = SEL_STAT;
         ADDR_W'(REG_MASK):   sel = SEL_MASK;
         ADDR_W'(REG_TXCTL):  sel = SEL_TXCTL;
         ADDR_W'(REG_TXMARK): sel = SEL_TXMARK;
         ADDR_W'(REG_RXCTL):  sel = SEL_RXCTL;
         ADDR_W'(REG_RXMARK): sel = SEL_RXMARK;
         ADDR_W'(REG_DATA):   sel = SEL_DATA;
         default:             sel = SEL_NONE;
      endcase
   end

   logic wr_stat, wr_mask, wr_txctl, wr_txmark, wr_rxctl, wr_rxmark, wr_data, rd_data;
   assign wr_stat   = bus_we && sel == SEL_STAT;
   assign wr_mask   = bus_we && sel == SEL_MASK;
   assign wr_txctl  = bus_we && sel == SEL_TXCTL;
   assign wr_txmark = bus_we && sel == SEL_TXMARK;
   assign wr_rxctl  = bus_we && sel == SEL_RXCTL;
   assign wr_rxmark = bus_we && sel == SEL_RXMARK;
   assign wr_data   = bus_we && sel == SEL_DATA;
   assign rd_data   = bus_re && sel == SEL_DATA;

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata[BUS_W-1:STAT_W];

   // queues
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic [BYTE_W-1:0] rx_head;

   codec_byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_data), .din(bus_wdata[BYTE_W-1:0]),
      .pop(txq_take), .head(txq_byte), .count(tx_cnt));

   codec_byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rxq_put), .din(rxq_byte),
      .pop(rd_data), .head(rx_head), .count(rx_cnt));

   assign txq_rdy = (tx_cnt != '0);

   // control state
   logic              tx_en_q, rx_en_q, evt_q;
   logic [MARK_W-1:0] tx_mark_q, rx_mark_q;
   logic [STAT_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q   <= 1'b0;
         rx_en_q   <= 1'b0;
         tx_mark_q <= MARK_W'(TX_MARK_RST);
         rx_mark_q <= MARK_W'(RX_MARK_RST);
         mask_q    <= '0;
         evt_q     <= 1'b0;
      end else begin
         if (wr_txctl)  tx_en_q   <= bus_wdata[0];
         if (wr_rxctl)  rx_en_q   <= bus_wdata[0];
         if (wr_txmark) tx_mark_q <= bus_wdata[MARK_W-1:0];
         if (wr_rxmark) rx_mark_q <= bus_wdata[MARK_W-1:0];
         if (wr_mask)   mask_q    <= bus_wdata[STAT_W-1:0];
         if (align_chg_i)                           evt_q <= 1'b1;
         else if (wr_stat && bus_wdata[ST_ALN_EVT]) evt_q <= 1'b0;
      end
   end

   assign tx_en_o = tx_en_q;
   assign rx_en_o = rx_en_q;

   // threshold flags
   logic tx_low, rx_high;
   codec_mark_cmp #(.CW(CW), .MW(MARK_W), .ABOVE(1'b0)) u_txmark (
      .count(tx_cnt), .mark(tx_mark_q), .hit(tx_low));
   codec_mark_cmp #(.CW(CW), .MW(MARK_W), .ABOVE(1'b1)) u_rxmark (
      .count(rx_cnt), .mark(rx_mark_q), .hit(rx_high));

   logic [STAT_W-1:0] stat;
   always_comb begin
      stat              = '0;
      stat[ST_TX_EMPTY] = (tx_cnt == '0);
      stat[ST_TX_LOW]   = tx_low;
      stat[ST_TX_FULL]  = (tx_cnt == CW'(DEPTH));
      stat[ST_RX_EMPTY] = (rx_cnt == '0);
      stat[ST_RX_HIGH]  = rx_high;
      stat[ST_RX_FULL]  = (rx_cnt == CW'(DEPTH));
      stat[ST_ALN_EVT]  = evt_q;
   end

   assign irq_o = |(stat & mask_q);

   // read path
   logic [BUS_W-1:0] rd_mux, rdata_q;
   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_STAT:   rd_mux = BUS_W'(stat);
         SEL_MASK:   rd_mux = BUS_W'(mask_q);
         SEL_TXCTL:  rd_mux = BUS_W'(tx_en_q);
         SEL_TXMARK: rd_mux = BUS_W'(tx_mark_q);
         SEL_RXCTL:  rd_mux = BUS_W'({align_i, rx_en_q});
         SEL_RXMARK: rd_mux = BUS_W'(rx_mark_q);
         SEL_DATA:   rd_mux = (rx_cnt != '0) ? BUS_W'(rx_head) : '0;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_re) rdata_q <= rd_mux;
   end
   assign bus_rdata = rdata_q;

   assert_evt_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      align_chg_i |=> evt_q);
   assert_evt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[ST_ALN_EVT] && !align_chg_i) |=> !evt_q);
   assert_evt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!align_chg_i && !wr_stat) |=> $stable(evt_q));
   assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);
   assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && rx_cnt == '0) |=> (bus_rdata == '0));
endmodule

// File: tb/codec_host_regs_tb.sv
module codec_host_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        tx_en_o, rx_en_o, txq_rdy, irq_o;
   logic [7:0]  txq_byte;
   logic        txq_take = 1'b0, rxq_put = 1'b0;
   logic [7:0]  rxq_byte = '0;
   logic        align_i = 1'b0, align_chg_i = 1'b0;

   int checks = 0, errs = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   codec_host_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .txq_rdy(txq_rdy), .txq_byte(txq_byte),
      .txq_take(txq_take), .rxq_put(rxq_put), .rxq_byte(rxq_byte),
      .align_i(align_i), .align_chg_i(align_chg_i), .irq_o(irq_o));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
         $finish;
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic take();
      @(negedge clk); txq_take = 1'b1;
      @(negedge clk); txq_take = 1'b0;
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); rxq_put = 1'b1; rxq_byte = b;
      @(negedge clk); rxq_put = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(16'h0000, v); chk("R1 status", v, 32'h011);
      rd(16'h0004, v); chk("R1 mask", v, 0);
      rd(16'h0010, v); chk("R1 txctl", v, 0);
      rd(16'h0014, v); chk("R1 txmark", v, 8);
      rd(16'h0020, v); chk("R1 rxctl", v, 0);
      rd(16'h0024, v); chk("R1 rxmark", v, 16);
      chk("R1 irq", irq_o, 0);
   endtask

   task automatic t_tx();
      logic [31:0] v;
      for (int i = 0; i < 33; i++) begin
         wr(16'h0100, 32'hFFFF_FF00 | (8'h40 + i));
         if (i == 0) begin
            rd(16'h0000, v);
            chk("R5 tx not empty", v[0], 0);
            chk("R2 head", txq_byte, 8'h40);
            chk("R2 rdy", txq_rdy, 1);
         end
         if (i == 7) begin rd(16'h0000, v); chk("R6 low at mark", v[1], 1); end
         if (i == 8) begin rd(16'h0000, v); chk("R6 low above mark", v[1], 0); end
      end
      rd(16'h0000, v); chk("R5 tx full", v[2:0], 3'b100);
      for (int i = 0; i < 32; i++) begin
         chk("R2 order", txq_byte, 8'h40 + i);
         take();
      end
      chk("R2 extra dropped", txq_rdy, 0);
      rd(16'h0000, v); chk("R5 tx empty again", v[2:0], 3'b001);
   endtask

   task automatic t_rx();
      logic [31:0] v;
      wr(16'h0024, 3);
      put(8'hA0); put(8'hA1);
      rd(16'h0000, v); chk("R7 below mark", v[6:4], 3'b000);
      put(8'hA2);
      rd(16'h0000, v); chk("R7 at mark", v[6:4], 3'b010);
      for (int i = 3; i < 33; i++) put(8'hA0 + i);
      rd(16'h0000, v); chk("R5 rx full", v[6:4], 3'b110);
      for (int i = 0; i < 32; i++) begin
         rd(16'h0100, v);
         chk("R3 R4 rx order", v, 8'hA0 + i);
      end
      rd(16'h0000, v); chk("R4 extra dropped", v[6:4], 3'b001);
      rd(16'h0100, v); chk("R3 empty read", v, 0);
      put(8'h5A);
      rd(16'h0100, v); chk("R3 after empty read", v, 8'h5A);
      wr(16'h0024, 16);
   endtask

   task automatic t_align_irq();
      logic [31:0] v;
      wr(16'h0004, 32'h100);
      chk("R10 masked quiet", irq_o, 0);
      @(negedge clk); align_i = 1'b1; align_chg_i = 1'b1;
      @(negedge clk); align_chg_i = 1'b0;
      chk("R10 irq on event", irq_o, 1);
      rd(16'h0000, v); chk("R8 set", v[8], 1);
      rd(16'h0020, v); chk("R9 align view", v, 32'h2);
      wr(16'h0000, 32'h0FF);
      rd(16'h0000, v); chk("R8 write0 keeps", v[8], 1);
      // clear and pulse in the same cycle: set wins
      @(negedge clk); bus_addr = 16'h0000; bus_wdata = 32'h100; bus_we = 1'b1; align_chg_i = 1'b1;
      @(negedge clk); bus_we = 1'b0; align_chg_i = 1'b0;
      rd(16'h0000, v); chk("R8 set wins", v[8], 1);
      wr(16'h0000, 32'h100);
      rd(16'h0000, v); chk("R8 cleared", v, 32'h011);
      chk("R10 irq drops", irq_o, 0);
      wr(16'h0004, 32'h001);
      chk("R10 tx empty irq", irq_o, 1);
      wr(16'h0004, 32'h0);
   endtask

   task automatic t_ctl_unused();
      logic [31:0] v;
      wr(16'h0010, 32'hFFFF_FFFF);
      chk("R9 tx_en", tx_en_o, 1);
      rd(16'h0010, v); chk("R11 txctl width", v, 1);
      wr(16'h0020, 32'hFFFF_FFFC);
      chk("R9 rx_en off", rx_en_o, 0);
      wr(16'h0020, 32'h1);
      chk("R9 rx_en", rx_en_o, 1);
      align_i = 1'b0;
      rd(16'h0020, v); chk("R9 align ro", v, 1);
      wr(16'h0014, 32'hFFFF_FFFF);
      rd(16'h0014, v); chk("R11 mark width", v, 32'h1F);
      wr(16'h0004, 32'hFFFF_FFFF);
      rd(16'h0004, v); chk("R11 mask width", v, 32'h1FF);
      wr(16'h0004, 0);
      wr(16'h0008, 32'hFFFF_FFFF);
      rd(16'h0008, v); chk("R11 unmapped", v, 0);
      rd(16'h0200, v); chk("R11 unmapped hi", v, 0);
      rd(16'h0000, v); chk("R11 no side effect", v, 32'h011);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx();
      t_rx();
      t_align_irq();
      t_ctl_unused();
      finish_run();
   end
endmodule